// File: doc/BRIEF.md
# Programmable LED Blink Generator Pair

This block holds two independent periodic pulse generators meant to blink indicator LEDs. Each channel has an 8-bit period and an 8-bit on-time, both counted in steps of a shared time base. A range select per channel picks the step size. In the fine range one step is one 1 ms tick, which gives up to 255 ms. In the coarse range one step is 125 ticks, which gives up to about 31.9 s. A period starts with the output in its active phase. The output stays active until the on-time count expires and is inactive for the rest of the period. A per-channel invert control flips the output polarity.

Software may write the period, on-time and range select at any time. The channel samples them only when it starts (enable) and at each period boundary, so a write never cuts a period short and never produces a glitch pulse. Dropping the enable returns the output to its inactive level on the next cycle and clears all counting state. Raising it again starts a fresh period in the active phase.

Each channel runs a four-state machine:
- **IDLE**: disabled, output inactive.
- **ON**: active phase.
- **OFF**: inactive phase.
- **ZERO**: the period is zero, so the output is held inactive.

Transitions:
- **START** leaves IDLE on enable. It goes to ZERO if the period is 0, to OFF if the on-time is 0, and to ON otherwise.
- **EXPIRE** moves from ON to OFF when the step count reaches the on-time.
- **WRAP** is the period boundary, from ON or OFF. It reloads the settings and re-enters ON, OFF or ZERO by the same rule as START.
- **RELOAD** re-samples the settings from ZERO on every step.
- **STOP** returns any state to IDLE when the enable drops.

Top module: `led_pgen_pair`

## Requirements
- R1: After reset every channel is in IDLE, and each output equals its invert control (low when the invert control is 0).
- R2: In the fine range (range select 0) one step is one `tick_ms` pulse. The output is active for the first on-time steps of each period and inactive for the remaining steps. The period is `period` steps long.
- R3: In the coarse range (range select 1) one step is 125 `tick_ms` pulses. The step counter is cleared at enable and at every period boundary.
- R4: An on-time greater than or equal to the period keeps the output continuously active.
- R5: A period of 0 holds the output inactive for as long as the channel is enabled.
- R6: A low enable makes the output inactive on the next cycle and clears the counters. A rising enable with nonzero period and on-time makes the output active on the next cycle. A `tick_ms` pulse in the enable cycle is not counted.
- R7: The output is the active-high phase XOR the invert control (bit 1 = inverted), and the invert control takes effect at once.
- R8: Period, on-time and range-select values written while the channel runs are used only from the next period boundary (from the next step when in ZERO).
- R9: The two channels are independent: the settings and enable of one never change the output of the other.
- R10: An on-time of 0 with a nonzero period keeps the output inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_ms | input | 1 | One-cycle pulse once per millisecond |
| gen_en | input | CHANNELS | Per-channel enable |
| gen_inv | input | CHANNELS | Per-channel output invert |
| gen_coarse | input | CHANNELS | Per-channel range select: 0 fine, 1 coarse |
| gen_period | input | CHANNELS*CNT_W | Per-channel period in steps, channel i at bits [i*CNT_W +: CNT_W] |
| gen_on | input | CHANNELS*CNT_W | Per-channel on-time in steps, same packing |
| gen_out | output | CHANNELS | Per-channel pulse output |

## Verification
The bench checks several corner cases, and a faulty design fails each one in a visible way:
- **On-time at or above the period.** A design that only compares against the on-time would blink with a one-step gap at every wrap.
- **Period of 0.** A design that subtracts one from the period would underflow and blink with a 256-step period.
- **Mid-period writes.** A design that reads the settings live would truncate or stretch the running period.
- **Enable edge.** Counting the enable-cycle tick, or not clearing the coarse divider, would shift every later edge of a coarse waveform by up to 125 ticks. The bench measures the exact high time across three coarse periods.

Disabling during the active phase, toggling the invert control, and activity on the other channel are all compared against a cycle-level model on every clock.

// File: rtl/led_pgen_pkg.sv
package led_pgen_pkg;

    typedef enum logic [1:0] {
        PG_IDLE = 2'd0,
        PG_ON   = 2'd1,
        PG_OFF  = 2'd2,
        PG_ZERO = 2'd3
    } pg_state_e;

endpackage

// File: rtl/led_pgen_step.sv
module led_pgen_step #(
    parameter int COARSE_DIV = 125
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic coarse_i,
    input  logic clear_i,
    output logic step_o
);

    localparam int DW = (COARSE_DIV > 1) ? $clog2(COARSE_DIV) : 1;

    generate
        if (COARSE_DIV > 1) begin : g_div
            logic [DW-1:0] dcnt_q;
            logic          wrap;

            assign wrap   = (dcnt_q == DW'(COARSE_DIV - 1));
            assign step_o = coarse_i ? (tick_i && wrap) : tick_i;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    dcnt_q <= '0;
                end else if (clear_i) begin
                    dcnt_q <= '0;
                end else if (tick_i) begin
                    dcnt_q <= wrap ? '0 : dcnt_q + DW'(1);
                end
            end

            AST_COARSE_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
                dcnt_q <= DW'(COARSE_DIV - 1)); // R3
        end else begin : g_pass
            logic unused_ctl;
            assign unused_ctl = coarse_i ^ clear_i;
            assign step_o     = tick_i;
        end
    endgenerate

    AST_STEP_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        step_o |-> tick_i); // R3

endmodule

// File: rtl/led_pgen_core.sv
module led_pgen_core
    import led_pgen_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             inv_i,
    input  logic             coarse_i,
    input  logic [CNT_W-1:0] period_i,
    input  logic [CNT_W-1:0] on_i,
    input  logic             step_i,
    output logic             coarse_q_o,
    output logic             clear_o,
    output logic             pulse_o
);

    pg_state_e          state_q, state_d;
    logic [CNT_W-1:0]   pos_q, pos_d;
    logic [CNT_W-1:0]   per_q, on_q;
    logic               crs_q;
    logic               load;
    logic               last;
    logic [CNT_W:0]     pos_inc;

    function automatic pg_state_e pick_entry(input logic [CNT_W-1:0] p,
                                             input logic [CNT_W-1:0] t);
        if (p == '0)      return PG_ZERO;
        else if (t == '0) return PG_OFF;
        else              return PG_ON;
    endfunction

    assign last    = (pos_q == per_q - CNT_W'(1));
    assign pos_inc = {1'b0, pos_q} + (CNT_W+1)'(1);

    // next-state and transition logic
    always_comb begin
        state_d = state_q;
        pos_d   = pos_q;
        load    = 1'b0;
        unique case (state_q)
            PG_IDLE: begin
                if (en_i) begin                    // START
                    load    = 1'b1;
                    pos_d   = '0;
                    state_d = pick_entry(period_i, on_i);
                end
            end
            PG_ON, PG_OFF: begin
                if (!en_i) begin                   // STOP
                    state_d = PG_IDLE;
                    pos_d   = '0;
                end else if (step_i) begin
                    if (last) begin                // WRAP
                        load    = 1'b1;
                        pos_d   = '0;
                        state_d = pick_entry(period_i, on_i);
                    end else begin                 // EXPIRE or stay
                        pos_d   = pos_inc[CNT_W-1:0];
                        state_d = (pos_inc < {1'b0, on_q}) ? PG_ON : PG_OFF;
                    end
                end
            end
            PG_ZERO: begin
                if (!en_i) begin                   // STOP
                    state_d = PG_IDLE;
                    pos_d   = '0;
                end else if (step_i) begin         // RELOAD
                    load    = 1'b1;
                    pos_d   = '0;
                    state_d = pick_entry(period_i, on_i);
                end
            end
            default: begin
                state_d = PG_IDLE;
                pos_d   = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PG_IDLE;
            pos_q   <= '0;
            per_q   <= '0;
            on_q    <= '0;
            crs_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            pos_q   <= pos_d;
            if (load) begin
                per_q <= period_i;
                on_q  <= on_i;
                crs_q <= coarse_i;
            end
        end
    end

    // outputs
    always_comb begin
        pulse_o    = (state_q == PG_ON) ^ inv_i;
        clear_o    = (state_q == PG_IDLE) || load || !en_i;
        coarse_q_o = crs_q;
    end

    AST_ON_BELOW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PG_ON) |-> (pos_q < on_q)); // R2
    AST_OFF_PAST_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PG_OFF) |-> (pos_q >= on_q)); // R10
    AST_POS_IN_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PG_ON || state_q == PG_OFF) |-> (pos_q < per_q)); // R2
    AST_ZERO_HOLDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PG_ZERO) |-> (per_q == '0 && pulse_o == inv_i)); // R5
    AST_STOP_INACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (state_q == PG_IDLE && pulse_o == inv_i && pos_q == '0)); // R6
    AST_START_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PG_IDLE && en_i && period_i != '0 && on_i != '0) |=> (state_q == PG_ON)); // R6
    AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != PG_IDLE && !load) |=> ($stable(per_q) && $stable(on_q) && $stable(crs_q))); // R8
    AST_FULL_ON_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PG_ON && en_i && on_q >= per_q && !(step_i && last)) |=> (state_q == PG_ON)); // R4

endmodule

// File: rtl/led_pgen_chan.sv
module led_pgen_chan #(
    parameter int CNT_W      = 8,
    parameter int COARSE_DIV = 125
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             en_i,
    input  logic             inv_i,
    input  logic             coarse_i,
    input  logic [CNT_W-1:0] period_i,
    input  logic [CNT_W-1:0] on_i,
    output logic             pulse_o
);

    logic step;
    logic coarse_q;
    logic clear;

    led_pgen_step #(
        .COARSE_DIV (COARSE_DIV)
    ) u_step (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (tick_i),
        .coarse_i (coarse_q),
        .clear_i  (clear),
        .step_o   (step)
    );

    led_pgen_core #(
        .CNT_W (CNT_W)
    ) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (en_i),
        .inv_i      (inv_i),
        .coarse_i   (coarse_i),
        .period_i   (period_i),
        .on_i       (on_i),
        .step_i     (step),
        .coarse_q_o (coarse_q),
        .clear_o    (clear),
        .pulse_o    (pulse_o)
    );

endmodule

// File: rtl/led_pgen_pair.sv
module led_pgen_pair #(
    parameter int CHANNELS   = 2,
    parameter int CNT_W      = 8,
    parameter int COARSE_DIV = 125
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      tick_ms,
    input  logic [CHANNELS-1:0]       gen_en,
    input  logic [CHANNELS-1:0]       gen_inv,
    input  logic [CHANNELS-1:0]       gen_coarse,
    input  logic [CHANNELS*CNT_W-1:0] gen_period,
    input  logic [CHANNELS*CNT_W-1:0] gen_on,
    output logic [CHANNELS-1:0]       gen_out
);

    generate
        for (genvar i = 0; i < CHANNELS; i++) begin : g_ch
            led_pgen_chan #(
                .CNT_W      (CNT_W),
                .COARSE_DIV (COARSE_DIV)
            ) u_chan (
                .clk      (clk),
                .rst_n    (rst_n),
                .tick_i   (tick_ms),
                .en_i     (gen_en[i]),
                .inv_i    (gen_inv[i]),
                .coarse_i (gen_coarse[i]),
                .period_i (gen_period[i*CNT_W +: CNT_W]),
                .on_i     (gen_on[i*CNT_W +: CNT_W]),
                .pulse_o  (gen_out[i])
            );
        end
    endgenerate

endmodule

// File: tb/led_pgen_pair_test.sv
module led_pgen_pair_test;

    localparam int CH  = 2;
    localparam int W   = 8;
    localparam int DIV = 125;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              tick = 1'b0;
    logic [CH-1:0]     en = '0, inv = '0, crs = '0;
    logic [CH*W-1:0]   per = '0, ont = '0;
    logic [CH-1:0]     gen_out;

    int checks = 0, errors = 0;
    int tick_gap = 2, tick_cnt = 0;
    int hi0 = 0, n0 = 0;
    string cur_req = "R1";

    // reference model state: 0 idle, 1 on, 2 off, 3 zero
    int m_st[CH]  = '{0, 0};
    int m_pos[CH] = '{0, 0};
    int m_p[CH]   = '{0, 0};
    int m_t[CH]   = '{0, 0};
    int m_c[CH]   = '{0, 0};
    int m_dv[CH]  = '{0, 0};

    led_pgen_pair #(.CHANNELS(CH), .CNT_W(W), .COARSE_DIV(DIV)) uut (
        .clk(clk), .rst_n(rst_n), .tick_ms(tick), .gen_en(en), .gen_inv(inv),
        .gen_coarse(crs), .gen_period(per), .gen_on(ont), .gen_out(gen_out)
    );

    always #5 clk = ~clk;

    function automatic int entry(input int p, input int t);
        if (p == 0) return 3;
        if (t == 0) return 2;
        return 1;
    endfunction

    always @(posedge clk) begin
        for (int c = 0; c < CH; c++) begin
            if (!rst_n) begin
                m_st[c] = 0; m_pos[c] = 0; m_p[c] = 0; m_t[c] = 0; m_c[c] = 0; m_dv[c] = 0;
            end else begin
                int  np, nt;
                bit  stp, clr;
                np  = int'(per[c*W +: W]);
                nt  = int'(ont[c*W +: W]);
                stp = (m_c[c] != 0) ? (tick && m_dv[c] == DIV-1) : tick;
                clr = 1'b0;
                if (!en[c]) begin
                    m_st[c] = 0; m_pos[c] = 0; clr = 1'b1;
                end else if (m_st[c] == 0) begin
                    m_p[c] = np; m_t[c] = nt; m_c[c] = int'(crs[c]);
                    m_pos[c] = 0; m_st[c] = entry(np, nt); clr = 1'b1;
                end else if (stp) begin
                    if (m_st[c] == 3 || m_pos[c] == m_p[c] - 1) begin
                        m_p[c] = np; m_t[c] = nt; m_c[c] = int'(crs[c]);
                        m_pos[c] = 0; m_st[c] = entry(np, nt); clr = 1'b1;
                    end else begin
                        m_pos[c] = m_pos[c] + 1;
                        m_st[c] = (m_pos[c] < m_t[c]) ? 1 : 2;
                    end
                end
                if (clr) m_dv[c] = 0;
                else if (tick) m_dv[c] = (m_dv[c] == DIV-1) ? 0 : m_dv[c] + 1;
            end
        end
    end

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic run(input int n);
        repeat (n) begin
            @(negedge clk);
            for (int c = 0; c < CH; c++)
                check(cur_req, gen_out[c], logic'(m_st[c] == 1) ^ inv[c]);
            n0++;
            if (gen_out[0]) hi0++;
            tick_cnt++;
            tick = (tick_cnt % tick_gap == 0);
        end
    endtask

    task automatic cfg(input int c, input int p, input int t, input logic cs);
        per[c*W +: W] = W'(p);
        ont[c*W +: W] = W'(t);
        crs[c] = cs;
    endtask

    task automatic clr_hist();
        hi0 = 0; n0 = 0;
    endtask

    initial begin
        #1;
        check("R1", gen_out[0], 1'b0);
        check("R1", gen_out[1], 1'b0);
        run(3);
        rst_n = 1'b1;
        run(2);
        check("R1", gen_out[0], 1'b0);

        // R9: channel 1 steady full-on while channel 0 is exercised
        cur_req = "R9";
        cfg(1, 7, 9, 1'b0); en[1] = 1'b1;

        cur_req = "R2";
        cfg(0, 10, 3, 1'b0); en[0] = 1'b1;
        run(300);

        cur_req = "R10";
        en[0] = 1'b0; run(2);
        cfg(0, 5, 0, 1'b0); en[0] = 1'b1;
        clr_hist(); run(100);
        check("R10", logic'(hi0 == 0), 1'b1);

        cur_req = "R4";
        en[0] = 1'b0; run(2);
        cfg(0, 6, 6, 1'b0); en[0] = 1'b1;
        run(1); clr_hist(); run(100);
        check("R4", logic'(hi0 == n0), 1'b1);
        cfg(0, 6, 200, 1'b0);
        run(30); clr_hist(); run(100);
        check("R4", logic'(hi0 == n0), 1'b1);

        cur_req = "R5";
        en[0] = 1'b0; run(2);
        cfg(0, 0, 5, 1'b0); en[0] = 1'b1;
        clr_hist(); run(50);
        check("R5", logic'(hi0 == 0), 1'b1);
        cur_req = "R8";
        cfg(0, 4, 2, 1'b0);
        run(60);

        cfg(0, 20, 10, 1'b0);
        run(100);
        cfg(0, 4, 1, 1'b0);
        run(120);
        cfg(0, 9, 4, 1'b1);
        run(40);
        cfg(0, 12, 5, 1'b0);
        run(150);

        cur_req = "R6";
        en[0] = 1'b0; run(2);
        cfg(0, 10, 8, 1'b0); en[0] = 1'b1;
        run(5);
        en[0] = 1'b0; run(1);
        check("R6", gen_out[0], 1'b0);
        check("R9", gen_out[1], 1'b1);
        en[0] = 1'b1; run(1);
        check("R6", gen_out[0], 1'b1);
        run(40);

        cur_req = "R7";
        inv[0] = 1'b1; run(1);
        en[0] = 1'b0; run(1);
        check("R7", gen_out[0], 1'b1);
        en[0] = 1'b1; run(1);
        check("R7", gen_out[0], 1'b0);
        run(60);
        inv[0] = 1'b0; run(2);

        cur_req = "R3";
        en = '0; run(2);
        tick_gap = 1;
        cfg(0, 3, 1, 1'b1);
        cfg(1, 10, 5, 1'b0);
        en = '1;
        clr_hist(); run(1125);
        check("R3", logic'(hi0 == 375), 1'b1);
        if (hi0 != 375) $display("FAIL R3 actual=%0d expected=375 high cycles", hi0);
        cur_req = "R8";
        cfg(0, 2, 1, 1'b0);
        run(300);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule